// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a small board-controller register file that a host reaches over a three-wire serial link: a serial clock, a data input and a data output. An active-low strobe is added to commit commands. Every bit the host clocks in while the strobe is high enters a 40-bit input frame. A rising serial clock edge taken while the strobe is low commits a command. The data-input level on that edge sets the direction: 1 means write and 0 means read.

On a write, the host first sends a 32-bit data word and then an 8-bit address. On a read, the host sends only the address. After the commit it clocks 32 more times and collects the selected register, most-significant bit first. Data in is sampled on rising serial edges, and data out changes on falling serial edges.

The register set holds the following:
- a mode word at 0x00 and a multiplexer word at 0x02, both writable;
- a live switch-input word at 0x08 and a version constant at 0xFF, both read-only;
- a reset-control word at 0x80. Writing 1 to its bit 0 drives a timed system-reset pulse.

The serial clock, strobe and data input are brought into the system clock domain through two flops. The serial clock must run at least four times slower than the system clock.

Top module: `serial_regfile_slave`

## Requirements
- R1: After reset, `ser_dout` is 1 and `sys_reset_out` is 0. The mode register reads MODE_INIT and the multiplexer register reads MUX_INIT.
- R2: Read sequence:
  - The host sends 8 address bits MSB first with the strobe high, then gives one strobe-low rising edge with data-in 0.
  - The next 32 serial clocks return the selected register MSB first.
  - Each bit is valid on `ser_dout` from the preceding falling serial edge.
- R3: Write sequence:
  - The host sends 32 data bits, then 8 address bits, both MSB first, then gives one strobe-low rising edge with data-in 1.
  - The last 8 bits before that edge are the address, and the 32 bits before them are the data.
- R4: Address 0x00 (mode) and address 0x02 (multiplexer) are 32-bit read/write registers.
- R5: Address 0x08 returns the `sw_status` input as sampled at the read commit. Writes to address 0x08 are ignored.
- R6: Address 0xFF returns the VERSION parameter. Writes to address 0xFF are ignored.
- R7: Reads of any other address return 0. Writes to any other address change no register.
- R8: Reset-control register at address 0x80:
  - Writing a word with bit 0 set drives `sys_reset_out` high for exactly RST_PULSE_CYCLES system clocks, after which the bit clears itself.
  - A read returns the bit in position 0 and zeros above it.
- R9: `ser_dout` is 1 at all times except while the 32 read bits are presented.
- R10: Rising serial edges with the strobe high only shift the input frame and never change a register. A version read as the first transaction leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host, idle low |
| ser_strobe_n | input | 1 | Active-low command strobe, idle high |
| ser_din | input | 1 | Serial data from the host, idle low |
| ser_dout | output | 1 | Serial data to the host, 1 when idle |
| sw_status | input | 32 | Switch inputs, returned at address 0x08 |
| sys_reset_out | output | 1 | System-reset pulse |

## Verification
A serial edge reaches the register logic three system clocks after the pin changes: two synchroniser flops, then the edge-detect flop. A commit therefore takes effect three clocks after its rising edge, and a read bit appears three clocks after its falling edge. The bench holds every serial level for four system clocks. It samples `ser_dout` on a system-clock falling edge just before the next rising serial edge, when the bit has been settled for at least one clock. Register writes are never probed directly; they are judged by later reads through the serial port. The reset pulse is measured by counting system clocks in which `sys_reset_out` is high, and that count is checked only after enough time has passed for the pulse to end.

// File: rtl/serial_regfile_slave.sv
module serial_regfile_slave #(
  parameter int          DATA_W           = 32,
  parameter int          ADDR_W           = 8,
  parameter int          SYNC_STAGES      = 2,
  parameter int          RST_PULSE_CYCLES = 16,
  parameter logic [31:0] MODE_INIT        = 32'h0000_0013,
  parameter logic [31:0] MUX_INIT         = 32'h0000_0000,
  parameter logic [31:0] VERSION          = 32'h0100_0002,
  parameter logic [7:0]  ADDR_MODE        = 8'h00,
  parameter logic [7:0]  ADDR_MUX         = 8'h02,
  parameter logic [7:0]  ADDR_SW          = 8'h08,
  parameter logic [7:0]  ADDR_RST         = 8'h80,
  parameter logic [7:0]  ADDR_VER         = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_strobe_n,
  input  logic              ser_din,
  output logic              ser_dout,
  input  logic [DATA_W-1:0] sw_status,
  output logic              sys_reset_out
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int PW      = $clog2(RST_PULSE_CYCLES + 1);

  logic [SYNC_STAGES:0]   clk_sh;
  logic [SYNC_STAGES-1:0] stb_sh, din_sh;
  logic [FRAME_W-1:0]     frame;
  logic [DATA_W-1:0]      mode_q, mux_q, out_sr, rd_val;
  logic [CNT_W-1:0]       rd_left;
  logic [PW-1:0]          rst_cnt;
  logic                   rst_bit, dout_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sh <= '0;
      stb_sh <= '1;
      din_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[SYNC_STAGES-1:0], ser_clk};
      stb_sh <= {stb_sh[SYNC_STAGES-2:0], ser_strobe_n};
      din_sh <= {din_sh[SYNC_STAGES-2:0], ser_din};
    end

  wire sclk      = clk_sh[SYNC_STAGES-1];
  wire sclk_d    = clk_sh[SYNC_STAGES];
  wire stb       = stb_sh[SYNC_STAGES-1];
  wire din       = din_sh[SYNC_STAGES-1];
  wire rise      = sclk & ~sclk_d;
  wire fall      = ~sclk & sclk_d;
  wire commit_wr = rise & ~stb & din;
  wire commit_rd = rise & ~stb & ~din;

  wire [ADDR_W-1:0] addr    = frame[ADDR_W-1:0];
  wire [DATA_W-1:0] wr_data = frame[FRAME_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      frame <= '0;
    else if (rise && stb)
      frame <= {frame[FRAME_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= MODE_INIT[DATA_W-1:0];
      mux_q  <= MUX_INIT[DATA_W-1:0];
    end else if (commit_wr) begin
      if (addr == ADDR_MODE) mode_q <= wr_data;
      if (addr == ADDR_MUX)  mux_q  <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_bit <= 1'b0;
      rst_cnt <= '0;
    end else if (commit_wr && addr == ADDR_RST) begin
      rst_bit <= wr_data[0];
      rst_cnt <= wr_data[0] ? PW'(RST_PULSE_CYCLES) : '0;
    end else if (rst_bit) begin
      if (rst_cnt <= PW'(1)) rst_bit <= 1'b0;
      rst_cnt <= rst_cnt - PW'(1);
    end

  always_comb
    case (addr)
      ADDR_MODE: rd_val = mode_q;
      ADDR_MUX:  rd_val = mux_q;
      ADDR_SW:   rd_val = sw_status;
      ADDR_RST:  rd_val = {{(DATA_W-1){1'b0}}, rst_bit};
      ADDR_VER:  rd_val = VERSION[DATA_W-1:0];
      default:   rd_val = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_sr  <= '0;
      rd_left <= '0;
      dout_q  <= 1'b1;
    end else if (commit_rd) begin
      out_sr  <= rd_val;
      rd_left <= CNT_W'(DATA_W);
    end else if (fall) begin
      if (rd_left != '0) begin
        dout_q  <= out_sr[DATA_W-1];
        out_sr  <= {out_sr[DATA_W-2:0], 1'b0};
        rd_left <= rd_left - CNT_W'(1);
      end else begin
        dout_q <= 1'b1;
      end
    end

  assign ser_dout      = dout_q;
  assign sys_reset_out = rst_bit;
endmodule

// File: rtl/serial_regfile_slave_chk.sv
module serial_regfile_slave_chk #(
  parameter int DATA_W           = 32,
  parameter int RST_PULSE_CYCLES = 16,
  parameter int CNT_W            = 6,
  parameter int PW               = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_wr,
  input logic              fall,
  input logic [CNT_W-1:0]  rd_left,
  input logic              ser_dout,
  input logic              sys_reset_out,
  input logic [PW-1:0]     rst_cnt,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] mux_q
);
  AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(mode_q)); // R10

  AST_MUX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(mux_q)); // R10

  AST_DOUT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && rd_left == '0) |=> ser_dout); // R9

  AST_READ_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_left <= CNT_W'(DATA_W)); // R2

  AST_RESET_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset_out && rst_cnt == PW'(1) && !commit_wr) |=> !sys_reset_out); // R8

  AST_RESET_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_out |-> rst_cnt != '0); // R8
endmodule

bind serial_regfile_slave serial_regfile_slave_chk #(
  .DATA_W(DATA_W), .RST_PULSE_CYCLES(RST_PULSE_CYCLES), .CNT_W(CNT_W), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_wr(commit_wr), .fall(fall),
  .rd_left(rd_left), .ser_dout(ser_dout), .sys_reset_out(sys_reset_out),
  .rst_cnt(rst_cnt), .mode_q(mode_q), .mux_q(mux_q)
);

// File: tb/serial_regfile_slave_bench.sv
module serial_regfile_slave_bench;
  localparam int          H     = 4;
  localparam int          PULSE = 16;
  localparam logic [31:0] M0    = 32'h0000_0013;
  localparam logic [31:0] X0    = 32'h0000_0000;
  localparam logic [31:0] VER   = 32'h0100_0002;

  logic clk = 0, rst_n = 0, sclk = 0, stb_n = 1, sdin = 0;
  logic [31:0] sw = 32'hCAFE_0001;
  logic dout, rst_out;
  int n_chk = 0, n_bad = 0, pulse_cnt = 0;
  bit done = 0;

  logic [31:0] exp_mode = M0, exp_mux = X0;

  always #2.5 clk = ~clk;

  serial_regfile_slave #(.RST_PULSE_CYCLES(PULSE), .MODE_INIT(M0), .MUX_INIT(X0),
    .VERSION(VER)) u_serial_regfile_slave (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_strobe_n(stb_n),
    .ser_din(sdin), .ser_dout(dout), .sw_status(sw), .sys_reset_out(rst_out));

  always @(negedge clk) if (rst_out) pulse_cnt++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdin = b; wait_clk(H);
    sclk = 1; wait_clk(H);
    sclk = 0; wait_clk(H);
  endtask

  task automatic commit(input logic b);
    stb_n = 0; pulse(b); stb_n = 1; sdin = 0; wait_clk(H);
  endtask

  task automatic do_read(input logic [7:0] a, input string req, output logic [31:0] v);
    for (int i = 7; i >= 0; i--) pulse(a[i]);
    check(dout === 1'b1, "R9 idle before read", {31'b0, dout}, 1);
    commit(1'b0);
    for (int i = 31; i >= 0; i--) begin
      v[i] = dout;
      pulse(1'b0);
    end
    check(dout === 1'b1, {req, " R9 idle after read"}, {31'b0, dout}, 1);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) pulse(d[i]);
    for (int i = 7; i >= 0; i--) pulse(a[i]);
    commit(1'b1);
  endtask

  function automatic logic [31:0] expect_at(input logic [7:0] a);
    case (a)
      8'h00:   return exp_mode;
      8'h02:   return exp_mux;
      8'h08:   return sw;
      8'h80:   return 32'h0;
      8'hFF:   return VER;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wait_clk(5); rst_n = 1; wait_clk(5);
    check(dout === 1'b1, "R1 dout after reset", {31'b0, dout}, 1);
    check(rst_out === 1'b0, "R1 reset output low", {31'b0, rst_out}, 0);

    do_read(8'hFF, "R10 dummy", v);
    check(v === VER, "R6 R10 dummy version read", v, VER);
    do_read(8'h00, "R1", v);
    check(v === M0, "R1 mode init", v, M0);
    do_read(8'h02, "R1", v);
    check(v === X0, "R1 mux init", v, X0);
    check(pulse_cnt == 0, "R10 no reset from dummy", pulse_cnt, 0);

    exp_mode = 32'hA5C3_0F12; do_write(8'h00, exp_mode);
    do_read(8'h00, "R4", v);
    check(v === exp_mode, "R3 R4 mode write", v, exp_mode);
    exp_mux = 32'h8123_4567; do_write(8'h02, exp_mux);
    do_read(8'h02, "R4", v);
    check(v === exp_mux, "R3 R4 mux write", v, exp_mux);
    do_read(8'h00, "R4", v);
    check(v === exp_mode, "R4 mode kept after mux write", v, exp_mode);

    do_write(8'h08, 32'h1111_2222);
    do_read(8'h08, "R5", v);
    check(v === sw, "R5 switch write ignored", v, sw);
    sw = 32'h0F0F_A0A0;
    do_read(8'h08, "R5", v);
    check(v === sw, "R5 switch follows input", v, sw);
    do_write(8'hFF, 32'hDEAD_BEEF);
    do_read(8'hFF, "R6", v);
    check(v === VER, "R6 version write ignored", v, VER);

    do_write(8'h55, 32'hFFFF_FFFF);
    do_write(8'h01, 32'h0);
    for (int i = 0; i < 40; i++) pulse(i[0]);
    do_read(8'h00, "R10", v);
    check(v === exp_mode, "R10 R7 mode after stray clocks", v, exp_mode);

    pulse_cnt = 0;
    do_write(8'h80, 32'h0000_0001);
    wait_clk(PULSE + 10);
    check(pulse_cnt == PULSE, "R8 reset pulse width", pulse_cnt, PULSE);
    check(rst_out === 1'b0, "R8 reset output cleared", {31'b0, rst_out}, 0);
    do_read(8'h80, "R8", v);
    check(v === 32'h0, "R8 reset bit self clears", v, 0);

    for (int a = 0; a < 256; a++) begin
      do_read(a[7:0], "R7 sweep", v);
      check(v === expect_at(a[7:0]), $sformatf("R7 sweep addr 0x%02h", a), v, expect_at(a[7:0]));
    end
    check(pulse_cnt == PULSE, "R10 reads cause no reset", pulse_cnt, PULSE);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule